// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank-State Checker

This block watches the command pins of a single-data-rate SDRAM bus from the memory side. On every rising clock edge it takes a sample of chip select, the three strobes (row, column, write), the two bank-select bits, address bit 10 and the remaining address bits. It turns the sample into a one-hot command code together with the target bank and the row or column address. The result appears on registered outputs one clock after the sampling edge.

Alongside the decode, the block tracks whether each of the four banks is idle or open. It also tracks whether a full-page burst is running, using the burst length supplied on a mode input. Every decoded command is qualified against this state, and any command that is not allowed in the current state raises a flag on the same output cycle. A flagged command leaves the tracked state untouched. Timing parameters and the data path are outside the block.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: While reset is asserted and on the first output cycle after its release, every output is zero. All banks start idle, no full-page burst is running, and the clock-enable history is taken as high.
- R2: A sampled command appears on `cmd_code` one cycle after its edge, with one bit set. Chip select high gives bit 0 (Deselect). With chip select low, the strobe values {ras_n,cas_n,we_n} map as follows: 111 gives bit 1 (NOP), 000 gives bit 2 (mode set), 011 gives bit 5 (activate), 010 gives bit 6 (precharge), 100 gives bit 7 (write), 101 gives bit 8 (read) and 110 gives bit 9 (burst stop).
- R3: A command is decoded only when `cke` was high at the previous edge; otherwise `cmd_code` is all zero. Code 001 gives bit 3 (auto refresh) when `cke` is high at the current edge, and bit 4 (self-refresh entry) when it is low.
- R4: `cmd_bank` carries the bank bits for activate, precharge, read and write, and is zero otherwise. `cmd_addr` is {a10, addr} for activate, {0, addr} for read and write, and zero otherwise. `auto_pre` is a10 on read and write. `pre_all` is a10 on precharge.
- R5: Activate is legal only on an idle bank, and a legal activate opens that bank.
- R6: Read and write are legal only on an open bank. With a10 high, a legal access closes that bank for every later command.
- R7: Precharge is never flagged. It closes the selected bank when a10 is low and all banks when a10 is high. Precharging an idle bank is accepted.
- R8: Mode set, auto refresh and self-refresh entry are flagged while any bank is open.
- R9: A full-page burst starts on a legal read or write with `burst_len` = 7 and a10 low. It ends on a legal burst stop, on a precharge covering its bank, or on any later legal read or write that does not itself start one. Burst stop is legal only while such a burst runs.
- R10: A flagged command changes no bank state and no burst state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge samples |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable pin |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| ba | input | 2 | Bank select |
| a10 | input | 1 | Address bit 10 (auto-precharge / all-banks) |
| addr | input | 12 | Remaining address bits |
| burst_len | input | 3 | Programmed burst length code, 7 = full page |
| cmd_code | output | 10 | One-hot decoded command |
| cmd_bank | output | 2 | Bank of the decoded command |
| cmd_addr | output | 13 | Row or column address |
| auto_pre | output | 1 | Read/write requests auto-precharge |
| pre_all | output | 1 | Precharge targets all banks |
| illegal | output | 1 | Command not allowed in current state |

## Verification
Bank and burst state is hidden, so a wrong entry first shows as a wrong `illegal` value on the next command that depends on it. That command may be an activate, an access, a mode set or a burst stop to the affected bank. The error is visible one cycle after that command's edge, but it may stay latent for many cycles until such a command arrives. Random traffic keeps the banks churning so that a wrong state is exposed within a few commands. Directed sequences cover burst stop after fixed-length and full-page accesses, auto-precharge closure, and suspended clock-enable cycles.

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor #(
  parameter int ADDR_W  = 12,
  parameter int BA_W    = 2,
  parameter int BL_W    = 3,
  parameter int BL_FULL = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [BA_W-1:0]   ba,
  input  logic              a10,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BL_W-1:0]   burst_len,
  output logic [9:0]        cmd_code,
  output logic [BA_W-1:0]   cmd_bank,
  output logic [ADDR_W:0]   cmd_addr,
  output logic              auto_pre,
  output logic              pre_all,
  output logic              illegal
);
  localparam int NB = 1 << BA_W;
  localparam int C_DSL = 0, C_NOP = 1, C_MRS = 2, C_ARF = 3, C_SRF = 4;
  localparam int C_ACT = 5, C_PRE = 6, C_WR = 7, C_RD = 8, C_BST = 9;

  logic          cke_q;
  logic [NB-1:0] bank_open;
  logic          fp_run;
  logic [BA_W-1:0] fp_bank;
  logic [9:0]    dec;

  always_comb begin
    dec = '0;
    if (cke_q) begin
      if (cs_n) dec[C_DSL] = 1'b1;
      else case ({ras_n, cas_n, we_n})
        3'b111: dec[C_NOP] = 1'b1;
        3'b000: dec[C_MRS] = 1'b1;
        3'b001: if (cke) dec[C_ARF] = 1'b1; else dec[C_SRF] = 1'b1;
        3'b011: dec[C_ACT] = 1'b1;
        3'b010: dec[C_PRE] = 1'b1;
        3'b100: dec[C_WR]  = 1'b1;
        3'b101: dec[C_RD]  = 1'b1;
        default: dec[C_BST] = 1'b1;
      endcase
    end
  end

  wire any_open = |bank_open;
  wire tgt_open = bank_open[ba];
  wire is_acc   = dec[C_RD] | dec[C_WR];
  wire is_glob  = dec[C_MRS] | dec[C_ARF] | dec[C_SRF];
  wire bad      = (is_glob & any_open) | (dec[C_ACT] & tgt_open) |
                  (is_acc & ~tgt_open) | (dec[C_BST] & ~fp_run);
  wire has_bank = dec[C_ACT] | dec[C_PRE] | is_acc;

  always_ff @(posedge clk) begin
    if (!rst_n) cke_q <= 1'b1;
    else        cke_q <= cke;
  end

  for (genvar i = 0; i < NB; i++) begin : g_bank
    wire hit = (ba == BA_W'(i));
    always_ff @(posedge clk) begin
      if (!rst_n) bank_open[i] <= 1'b0;
      else if (!bad) begin
        if (dec[C_ACT] && hit)                bank_open[i] <= 1'b1;
        else if (dec[C_PRE] && (a10 || hit))  bank_open[i] <= 1'b0;
        else if (is_acc && a10 && hit)        bank_open[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fp_run  <= 1'b0;
      fp_bank <= '0;
    end else if (!bad) begin
      if (is_acc) begin
        fp_run  <= (burst_len == BL_W'(BL_FULL)) && !a10;
        fp_bank <= ba;
      end else if (dec[C_BST]) begin
        fp_run <= 1'b0;
      end else if (dec[C_PRE] && (a10 || ba == fp_bank)) begin
        fp_run <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_code <= '0;
      cmd_bank <= '0;
      cmd_addr <= '0;
      auto_pre <= 1'b0;
      pre_all  <= 1'b0;
      illegal  <= 1'b0;
    end else begin
      cmd_code <= dec;
      cmd_bank <= has_bank ? ba : '0;
      cmd_addr <= dec[C_ACT] ? {a10, addr} : (is_acc ? {1'b0, addr} : '0);
      auto_pre <= is_acc & a10;
      pre_all  <= dec[C_PRE] & a10;
      illegal  <= bad;
    end
  end

  // R2
  onehot_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmd_code));
  // R3
  suspend_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cke_q |=> (cmd_code == '0));
  // R5
  act_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code[C_ACT] && !illegal) |-> bank_open[cmd_bank]);
  // R6
  autopre_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_pre && !illegal) |-> !bank_open[cmd_bank]);
  // R7
  pre_all_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pre_all |-> (bank_open == '0));
  // R9
  burst_on_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fp_run |-> bank_open[fp_bank]);
  // R10
  illegal_has_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (cmd_code != '0 && !cmd_code[C_PRE] && !cmd_code[C_NOP] && !cmd_code[C_DSL]));
endmodule

// File: tb/sim_sdram_cmd_monitor.sv
module sim_sdram_cmd_monitor;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0] ba = '0;
  logic a10 = 1'b0;
  logic [11:0] addr = '0;
  logic [2:0] burst_len = 3'd3;
  logic [9:0] cmd_code;
  logic [1:0] cmd_bank;
  logic [12:0] cmd_addr;
  logic auto_pre, pre_all, illegal;

  int checks = 0, fails = 0, cycles = 0;
  logic [3:0] m_open = '0;
  logic m_fp = 1'b0;
  logic [1:0] m_fpb = '0;
  logic m_ckeq = 1'b1;

  always #2.5 clk = ~clk;

  sdram_cmd_monitor u0 (.clk, .rst_n, .cke, .cs_n, .ras_n, .cas_n, .we_n, .ba, .a10,
    .addr, .burst_len, .cmd_code, .cmd_bank, .cmd_addr, .auto_pre, .pre_all, .illegal);

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int exp_idx(input logic ckq, input logic ck, input logic cs,
                                 input logic [2:0] s);
    if (!ckq) return -1;
    if (cs) return 0;
    case (s)
      3'b111: return 1;
      3'b000: return 2;
      3'b001: return ck ? 3 : 4;
      3'b011: return 5;
      3'b010: return 6;
      3'b100: return 7;
      3'b101: return 8;
      default: return 9;
    endcase
  endfunction

  task automatic step(input logic ck, input logic cs, input logic [2:0] s,
                      input logic [1:0] b, input logic a, input logic [11:0] ad,
                      input logic [2:0] bl);
    int k;
    logic bad, acc;
    logic [9:0] ec;
    string rq;
    cke = ck; cs_n = cs; {ras_n, cas_n, we_n} = s; ba = b; a10 = a; addr = ad; burst_len = bl;
    k = exp_idx(m_ckeq, ck, cs, s);
    ec = (k < 0) ? 10'd0 : (10'd1 << k);
    acc = (k == 7 || k == 8);
    bad = 1'b0; rq = "R7";
    if (k >= 2 && k <= 4) begin bad = |m_open; rq = "R8"; end
    if (k == 5) begin bad = m_open[b]; rq = "R5"; end
    if (acc) begin bad = !m_open[b]; rq = "R6"; end
    if (k == 9) begin bad = !m_fp; rq = "R9"; end
    @(posedge clk); @(negedge clk);
    check(m_ckeq ? "R2" : "R3", "cmd_code", int'(cmd_code), int'(ec));
    check("R4", "cmd_bank", int'(cmd_bank), (k >= 5 && k <= 8) ? int'(b) : 0);
    check("R4", "cmd_addr", int'(cmd_addr),
          k == 5 ? int'({a, ad}) : (acc ? int'(ad) : 0));
    check("R4", "auto_pre", int'(auto_pre), int'(acc & a));
    check("R4", "pre_all", int'(pre_all), int'(k == 6 && a));
    check(rq, "illegal", int'(illegal), int'(bad));
    // R10: state moves only for accepted commands
    if (!bad) begin
      if (k == 5) m_open[b] = 1'b1;
      if (k == 6) begin
        if (a) m_open = '0; else m_open[b] = 1'b0;
        if (a || b == m_fpb) m_fp = 1'b0;
      end
      if (acc) begin
        if (a) m_open[b] = 1'b0;
        m_fp = (bl == 3'd7) && !a;
        m_fpb = b;
      end
      if (k == 9) m_fp = 1'b0;
    end
    m_ckeq = ck;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  localparam logic [2:0] MRS = 3'b000, REF = 3'b001, ACT = 3'b011, PRE = 3'b010,
                         WR = 3'b100, RD = 3'b101, BST = 3'b110, NOP = 3'b111;

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1: outputs zero in reset
    check("R1", "reset cmd_code", int'(cmd_code), 0);
    check("R1", "reset illegal", int'(illegal), 0);
    rst_n = 1'b1;
    // R1/R9: burst stop right after reset is rejected; banks idle
    step(1, 0, BST, 0, 0, 0, 7);
    step(1, 0, RD, 1, 0, 12'h0a5, 3);          // R6 read on idle bank
    step(1, 0, ACT, 1, 1, 12'h123, 3);         // R5 open bank 1
    step(1, 0, ACT, 1, 0, 12'h001, 3);         // R5 second activate flagged
    step(1, 0, MRS, 0, 0, 12'h030, 3);         // R8 mode set while open
    step(1, 0, REF, 0, 0, 0, 3);               // R8 refresh while open
    step(1, 0, RD, 1, 0, 12'h040, 3);          // fixed burst
    step(1, 0, BST, 0, 0, 0, 3);               // R9 stop on fixed burst flagged
    step(1, 0, WR, 1, 0, 12'h050, 7);          // R9 full page starts
    step(1, 0, BST, 2, 0, 0, 7);               // R9 stop accepted
    step(1, 0, BST, 2, 0, 0, 7);               // R9 second stop flagged
    step(1, 0, RD, 1, 0, 12'h060, 7);
    step(1, 0, PRE, 1, 0, 0, 7);               // R7 closes bank 1, ends burst
    step(1, 0, BST, 0, 0, 0, 7);               // R9
    step(1, 0, PRE, 3, 0, 0, 7);               // R7 idle bank precharge
    step(1, 0, ACT, 2, 0, 12'h777, 3);
    step(1, 0, WR, 2, 1, 12'h010, 3);          // R6 auto-precharge
    step(1, 0, RD, 2, 0, 12'h010, 3);          // R6 now idle, flagged
    step(1, 0, ACT, 0, 0, 12'h004, 3);
    step(1, 0, ACT, 3, 0, 12'h005, 3);
    step(0, 0, NOP, 0, 0, 0, 3);               // R3 cke falls
    step(0, 0, RD, 0, 0, 0, 3);                // R3 ignored while suspended
    step(1, 0, NOP, 0, 0, 0, 3);
    step(1, 0, PRE, 0, 1, 0, 3);               // R7 all banks
    step(1, 0, MRS, 0, 0, 12'h022, 3);         // R8 legal now
    step(0, 0, REF, 0, 0, 0, 3);               // R3 self refresh entry
    step(0, 1, NOP, 0, 0, 0, 3);
    step(1, 1, NOP, 0, 0, 0, 3);
    step(1, 0, REF, 0, 0, 0, 3);               // R3 auto refresh
    for (int i = 0; i < 4000; i++) begin
      logic ck, cs;
      logic [2:0] s, bl;
      ck = ($urandom % 20) != 0;
      cs = ($urandom % 10) == 0;
      s  = 3'($urandom);
      bl = ($urandom % 2) ? 3'd7 : 3'($urandom % 4);
      step(ck, cs, s, 2'($urandom), ($urandom % 10) < 3, 12'($urandom), bl);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule